// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host access to the global configuration space of an I/O controller through two byte-wide I/O ports: an index port that selects a register and a data port that reads or writes the selected register. The registers are protected by a lock. The host opens it by writing an entry key twice in a row to the index port and closes it again with a distinct exit key. While the lock is closed, the data port has no effect.

Behind the port sits a small global register file. It holds a software-reset control, a logical device number (LDN), read-only chip and vendor identifier bytes, and a bank of per-device registers for each logical device. The LDN chooses which bank the bank indices reach. A strap input, sampled once after hardware reset, moves the port pair between two fixed I/O addresses.

The bus is synchronous. A single-cycle write or read strobe carries a 16-bit address, and read data is returned registered one cycle after the read strobe.

Top module: `keyed_cfg_port`

## Requirements
- R1: After hardware reset the port is locked, the index is 0x00 and the LDN and all bank registers are 0x00.
- R2: The strap is sampled on the first clock edge after reset release. High selects index 0x4E and data 0x4F, low selects index 0x2E and data 0x2F. Later strap changes do not move the ports.
- R3: The port unlocks only after two consecutive index-port writes of 0x87. Any other value written while locked, including one between the two keys, restarts the sequence.
- R4: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R5: While unlocked, an index-port write of any value except 0xAA latches that value as the index, and an index-port read returns the current index.
- R6: While unlocked, an index-port write of 0xAA locks the port and leaves the index unchanged.
- R7: Index 0x20/0x21 read the chip identifier high/low byte and 0x23/0x24 read the vendor identifier high/low byte. Writes to these indices have no effect.
- R8: Index 0x07 is the LDN and reads back the full written byte. Indices 0x30 up to 0x30+DEV_REGS-1 reach the bank of device LDN when LDN < NUM_DEV. Otherwise they read 0x00 and ignore writes.
- R9: A data write to index 0x02 with bit 0 set clears the LDN, all bank registers and the index to 0x00. The port stays unlocked and index 0x02 reads 0x00.
- R10: Unimplemented indices read 0x00 and ignore writes.
- R11: rdata_o changes only in the cycle after a read strobe that hits one of the two ports. Accesses to any other address leave rdata_o and all state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| strap_i | input | 1 | Base-address strap, sampled after reset |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
The bench builds the block with NUM_DEV=3 and DEV_REGS=2, so only a few LDN values and bank indices are valid. Random traffic therefore often hits an out-of-range LDN (3 and above) or a bank index past the end, not only the valid banks. The bench also runs from two hardware resets with opposite strap levels, so both port pairs are reached. In each run, writes sent to the unselected pair are shown to be ignored.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [1:0] {ST_LOCKED, ST_HALF, ST_OPEN} lock_state_e;

  localparam byte_t IDX_SWRST   = 8'h02;
  localparam byte_t IDX_LDN     = 8'h07;
  localparam byte_t IDX_CHIP_HI = 8'h20;
  localparam byte_t IDX_CHIP_LO = 8'h21;
  localparam byte_t IDX_VEND_HI = 8'h23;
  localparam byte_t IDX_VEND_LO = 8'h24;
  localparam byte_t IDX_BANK    = 8'h30;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
#(
  parameter byte_t ENTRY_KEY = 8'h87,
  parameter byte_t EXIT_KEY  = 8'hAA
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idx_wr_i,
  input  byte_t wdata_i,
  output logic  unlocked_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idx_wr_i) begin
      unique case (state_q)
        ST_LOCKED: state_d = (wdata_i == ENTRY_KEY) ? ST_HALF : ST_LOCKED;
        ST_HALF:   state_d = (wdata_i == ENTRY_KEY) ? ST_OPEN : ST_LOCKED;
        ST_OPEN:   state_d = (wdata_i == EXIT_KEY) ? ST_LOCKED : ST_OPEN;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOCKED;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == ST_OPEN);

  p_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALF && idx_wr_i && wdata_i == ENTRY_KEY) |=> unlocked_o);
  p_break_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked_o && idx_wr_i && wdata_i != ENTRY_KEY) |=> !unlocked_o);
  p_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unlocked_o && idx_wr_i && wdata_i == EXIT_KEY) |=> !unlocked_o);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
#(
  parameter int          NUM_DEV   = 8,
  parameter int          DEV_REGS  = 8,
  parameter logic [15:0] CHIP_ID   = 16'h5A31,
  parameter logic [15:0] VENDOR_ID = 16'h19C4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  logic  swrst_i,
  input  byte_t idx_i,
  input  byte_t wdata_i,
  output byte_t rdata_o
);
  localparam int SLOT_W = (DEV_REGS > 1) ? $clog2(DEV_REGS) : 1;
  localparam int SEL_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  byte_t            ldn_q;
  logic             in_bank, ldn_ok;
  logic [SLOT_W-1:0] slot;
  byte_t            bank_rd [NUM_DEV];

  assign in_bank = ({1'b0, idx_i} >= {1'b0, IDX_BANK}) &&
                   ({1'b0, idx_i} <  ({1'b0, IDX_BANK} + 9'(DEV_REGS)));
  assign ldn_ok  = (int'(ldn_q) < NUM_DEV);
  assign slot    = SLOT_W'(idx_i - IDX_BANK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ldn_q <= '0;
    else if (swrst_i)                        ldn_q <= '0;
    else if (wr_en_i && idx_i == IDX_LDN)    ldn_q <= wdata_i;
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    byte_t regs_q [DEV_REGS];
    logic  sel;
    assign sel = wr_en_i && in_bank && ldn_ok && (ldn_q == 8'(d));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < DEV_REGS; r++) regs_q[r] <= '0;
      end else if (swrst_i) begin
        for (int r = 0; r < DEV_REGS; r++) regs_q[r] <= '0;
      end else if (sel) begin
        regs_q[slot] <= wdata_i;
      end
    end
    assign bank_rd[d] = in_bank ? regs_q[slot] : '0;
  end

  always_comb begin
    unique case (idx_i)
      IDX_LDN:     rdata_o = ldn_q;
      IDX_CHIP_HI: rdata_o = CHIP_ID[15:8];
      IDX_CHIP_LO: rdata_o = CHIP_ID[7:0];
      IDX_VEND_HI: rdata_o = VENDOR_ID[15:8];
      IDX_VEND_LO: rdata_o = VENDOR_ID[7:0];
      default:     rdata_o = (in_bank && ldn_ok) ? bank_rd[ldn_q[SEL_W-1:0]] : '0;
    endcase
  end

  p_swrst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_i |=> (ldn_q == '0));
  p_ldn_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !swrst_i && idx_i == IDX_LDN) |=> (ldn_q == $past(wdata_i)));
  p_ldn_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !swrst_i) |=> $stable(ldn_q));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_DEF  = 16'h004E,
  parameter logic [15:0] BASE_ALT  = 16'h002E,
  parameter byte_t       ENTRY_KEY = 8'h87,
  parameter byte_t       EXIT_KEY  = 8'hAA,
  parameter int          NUM_DEV   = 8,
  parameter int          DEV_REGS  = 8,
  parameter logic [15:0] CHIP_ID   = 16'h5A31,
  parameter logic [15:0] VENDOR_ID = 16'h19C4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  logic              strap_done_q, alt_sel_q, alt_sel;
  logic [ADDR_W-1:0] idx_addr, dat_addr;
  logic              hit_idx, hit_dat, unlocked, swrst, reg_wr;
  byte_t             index_q, reg_rd, rdata_q;

  // strap latched once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      alt_sel_q    <= 1'b0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      alt_sel_q    <= !strap_i;
    end
  end

  assign alt_sel  = strap_done_q ? alt_sel_q : !strap_i;
  assign idx_addr = ADDR_W'(alt_sel ? BASE_ALT : BASE_DEF);
  assign dat_addr = idx_addr + ADDR_W'(1);
  assign hit_idx  = (addr_i == idx_addr);
  assign hit_dat  = (addr_i == dat_addr);

  cfg_key_fsm #(.ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (wr_i && hit_idx),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  assign reg_wr = wr_i && hit_dat && unlocked;
  assign swrst  = reg_wr && (index_q == IDX_SWRST) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              index_q <= '0;
    else if (swrst)                                           index_q <= '0;
    else if (wr_i && hit_idx && unlocked && wdata_i != EXIT_KEY) index_q <= wdata_i;
  end

  cfg_regfile #(
    .NUM_DEV(NUM_DEV), .DEV_REGS(DEV_REGS),
    .CHIP_ID(CHIP_ID), .VENDOR_ID(VENDOR_ID)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (reg_wr),
    .swrst_i (swrst),
    .idx_i   (index_q),
    .wdata_i (wdata_i),
    .rdata_o (reg_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_q <= 8'hFF;
    else if (rd_i && hit_idx)    rdata_q <= unlocked ? index_q : 8'hFF;
    else if (rd_i && hit_dat)    rdata_q <= unlocked ? reg_rd : 8'hFF;
  end

  assign rdata_o = rdata_q;

  p_locked_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlocked && rd_i && (hit_idx || hit_dat)) |=> (rdata_o == 8'hFF));
  p_strap_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done_q |=> $stable(alt_sel_q));
  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && (hit_idx || hit_dat)) |=> $stable(rdata_o));
  p_exit_idx_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit_idx && wdata_i == EXIT_KEY) |=> $stable(index_q));
endmodule

// File: tb/sim_keyed_cfg_port.sv
`timescale 1ns/1ps
module sim_keyed_cfg_port;
  localparam int NDEV = 3;
  localparam int NREG = 2;
  localparam logic [15:0] CHIP = 16'h5A31;
  localparam logic [15:0] VEND = 16'h19C4;

  logic clk = 1'b0, rst_n = 1'b0, strap = 1'b1;
  logic [15:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  keyed_cfg_port #(.NUM_DEV(NDEV), .DEV_REGS(NREG)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata));

  // reference model
  int          m_state;
  logic [7:0]  m_idx, m_ldn, m_last;
  logic [7:0]  m_bank [NDEV][NREG];
  logic [15:0] m_base;

  function automatic logic [7:0] exp_reg();
    int b;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return CHIP[15:8];
      8'h21: return CHIP[7:0];
      8'h23: return VEND[15:8];
      8'h24: return VEND[7:0];
      default: begin
        b = int'(m_idx) - 'h30;
        if (b >= 0 && b < NREG && int'(m_ldn) < NDEV) return m_bank[m_ldn][b];
        return 8'h00;
      end
    endcase
  endfunction

  task automatic model_clear();
    m_ldn = 0; m_idx = 0;
    for (int d = 0; d < NDEV; d++) for (int r = 0; r < NREG; r++) m_bank[d][r] = 0;
  endtask

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = 16'h0000;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; addr = 16'h0000; d = rdata;
  endtask

  task automatic idx_wr(input logic [7:0] v);
    bus_wr(m_base, v);
    case (m_state)
      0: m_state = (v == 8'h87) ? 1 : 0;
      1: m_state = (v == 8'h87) ? 2 : 0;
      default: if (v == 8'hAA) m_state = 0; else m_idx = v;
    endcase
  endtask

  task automatic dat_wr(input logic [7:0] v);
    int b;
    bus_wr(m_base + 16'd1, v);
    if (m_state == 2) begin
      b = int'(m_idx) - 'h30;
      if (m_idx == 8'h02 && v[0]) model_clear();
      else if (m_idx == 8'h07) m_ldn = v;
      else if (b >= 0 && b < NREG && int'(m_ldn) < NDEV) m_bank[m_ldn][b] = v;
    end
  endtask

  task automatic chk_idx(input string req);
    logic [7:0] d, e;
    bus_rd(m_base, d);
    e = (m_state == 2) ? m_idx : 8'hFF;
    m_last = e;
    check(d === e, req, d, e);
  endtask

  task automatic chk_dat(input string req);
    logic [7:0] d, e;
    bus_rd(m_base + 16'd1, d);
    e = (m_state == 2) ? exp_reg() : 8'hFF;
    m_last = e;
    check(d === e, req, d, e);
  endtask

  task automatic do_reset(input logic s);
    @(negedge clk); rst_n = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    m_state = 0; model_clear(); m_last = 8'hFF;
    m_base = s ? 16'h004E : 16'h002E;
  endtask

  task automatic open_port();
    idx_wr(8'h87); idx_wr(8'h87);
  endtask

  task automatic random_phase(input int n);
    logic [7:0] d, v;
    int k;
    for (int i = 0; i < n; i++) begin
      k = $urandom_range(0, 9);
      case (k)
        0: idx_wr(($urandom_range(0, 3) == 0) ? 8'hAA : 8'h87);
        1, 2: begin
          case ($urandom_range(0, 5))
            0: v = 8'h07; 1: v = 8'h02;
            2: v = 8'h20 + 8'($urandom_range(0, 4));
            3, 4: v = 8'h30 + 8'($urandom_range(0, 3));
            default: v = 8'($urandom);
          endcase
          if (m_state == 2 || $urandom_range(0, 1) == 0) idx_wr(v);
        end
        3, 4: begin
          v = (m_idx == 8'h07) ? 8'($urandom_range(0, 4)) : 8'($urandom);
          if (m_idx == 8'h02 && $urandom_range(0, 2) != 0) v[0] = 1'b0;
          dat_wr(v);
        end
        5, 6: chk_dat("R8 random data read");
        7: chk_idx("R5 random index read");
        8: begin
          bus_wr(m_base ^ 16'h0060, 8'($urandom));
          bus_wr(16'($urandom), 8'h87);
        end
        default: begin
          bus_rd(m_base ^ 16'h0060, d);
          check(d === m_last, "R11 foreign read holds", d, m_last);
        end
      endcase
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'h0C0FFEE5));
    // run 1: strap low -> alternate pair
    do_reset(1'b0);
    chk_dat("R1 reset data read locked");
    chk_idx("R1 reset index read locked");
    strap = 1'b1;                          // R2 late change must be ignored
    bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h87);
    chk_idx("R2 unselected pair does not unlock");
    idx_wr(8'h87); idx_wr(8'h55); idx_wr(8'h87);
    chk_idx("R3 broken key sequence stays locked");
    dat_wr(8'h03);
    chk_dat("R4 locked data write ignored");
    idx_wr(8'h87);
    chk_idx("R3 two consecutive keys unlock");
    chk_dat("R1 index 0 reads zero");
    idx_wr(8'h20); chk_dat("R7 chip id hi");
    dat_wr(8'h00); chk_dat("R7 chip id write ignored");
    idx_wr(8'h21); chk_dat("R7 chip id lo");
    idx_wr(8'h23); chk_dat("R7 vendor id hi");
    idx_wr(8'h24); chk_dat("R7 vendor id lo");
    idx_wr(8'h07); dat_wr(8'h02); chk_dat("R8 ldn readback");
    idx_wr(8'h31); dat_wr(8'hC3); chk_dat("R8 bank write dev2");
    idx_wr(8'h07); dat_wr(8'h09); chk_dat("R8 ldn out of range stored");
    idx_wr(8'h31); chk_dat("R8 out of range ldn reads zero");
    dat_wr(8'h5E);
    idx_wr(8'h07); dat_wr(8'h02);
    idx_wr(8'h31); chk_dat("R8 write under bad ldn dropped");
    idx_wr(8'h32); dat_wr(8'h77); chk_dat("R8 index past bank reads zero");
    idx_wr(8'h5C); dat_wr(8'hA5); chk_dat("R10 reserved index reads zero");
    idx_wr(8'h02); chk_dat("R9 swrst reads zero");
    dat_wr(8'h00);
    idx_wr(8'h31); chk_dat("R9 swrst bit0 clear no effect");
    idx_wr(8'h02); dat_wr(8'h01);
    chk_idx("R9 swrst clears index, stays unlocked");
    idx_wr(8'h07); chk_dat("R9 swrst clears ldn");
    idx_wr(8'h07); dat_wr(8'h02); idx_wr(8'h31); chk_dat("R9 swrst clears bank");
    idx_wr(8'h24); idx_wr(8'hAA);
    chk_idx("R6 exit key locks");
    open_port();
    chk_idx("R6 index kept across exit");
    bus_rd(16'h1234, d);
    check(d === m_last, "R11 foreign read holds rdata", d, m_last);
    random_phase(1500);
    // run 2: strap high -> default pair
    do_reset(1'b1);
    strap = 1'b0;
    chk_dat("R1 reset after second reset");
    bus_wr(16'h002E, 8'h87); bus_wr(16'h002E, 8'h87);
    chk_idx("R2 alternate pair ignored when strap high");
    open_port();
    chk_idx("R2 default pair unlocks");
    random_phase(1500);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule